// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single-word messages between two ports that run on unrelated clocks, alongside a data FIFO that lives elsewhere. Each port shares its control pins with that FIFO: a chip select, a direction select, an enable and a mailbox select. When the mailbox select is high, an enabled access goes to the mailbox path. Mailbox 1 carries messages from port A to port B, and mailbox 2 carries them from port B to port A.

Each mailbox has one data register and an active-low full flag. The flag has one copy in the writer's clock domain and one in the reader's. A write lowers the writer copy at once. The reader copy falls after the event crosses a two-flop toggle synchronizer. A read raises the reader copy at once, and the acknowledgement then crosses back to raise the writer copy. A writer whose flag is low cannot overwrite the unread word. The data buses are modelled as a data vector plus an output-enable bit. With the mailbox select high, the bus shows the mailbox word; with it low, the bus shows the FIFO word supplied from outside.

Top module: `mbox_pair`

## Requirements
- R1: While rst_ni is low, all four full flags read high and both mailbox words read zero; reset takes effect without waiting for a clock.
- R2: On a rising clk_a_i with a_cs_ni low, a_wr_i high, a_en_i high, a_mb_i high and a_mb1_full_no high, mailbox 1 stores a_dat_i, and a_mb1_full_no is low after that same edge.
- R3: On a rising clk_b_i with b_cs_ni low, b_rd_i low, b_en_i high, b_mb_i high and b_mb2_full_no high, mailbox 2 stores b_dat_i, and b_mb2_full_no is low after that same edge.
- R4: A write to a mailbox whose writer-side flag is low is ignored: the stored word and both of its flags stay unchanged.
- R5: After a mailbox write, the reader-side flag stays high through the first two reader-clock rising edges after the write edge, and is low by the fourth.
- R6: A read is b_cs_ni low, b_rd_i high, b_en_i high and b_mb_i high for mailbox 1, or a_cs_ni low, a_wr_i low, a_en_i high and a_mb_i high for mailbox 2. If the reader-side flag is low, a read raises that flag at the same edge. The writer-side flag stays low through two writer-clock edges after the read, and is high by the fourth.
- R7: When a port's output enable is high, its data output shows the word of the mailbox it reads if its mailbox select is high, and its FIFO input word if the select is low. When the enable is low, the data output is zero.
- R8: a_oe_o is high exactly when a_cs_ni and a_wr_i are both low. b_oe_o is high exactly when b_cs_ni is low and b_rd_i is high.
- R9: A read attempt with the enable low, or with the mailbox select low, leaves the reader-side flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronized per domain on release |
| a_cs_ni | input | 1 | Port A chip select, active low |
| a_wr_i | input | 1 | Port A direction: 1 = write into block, 0 = drive outputs |
| a_en_i | input | 1 | Port A access enable |
| a_mb_i | input | 1 | Port A mailbox select |
| a_dat_i | input | 36 | Port A write data |
| a_fifo_i | input | 36 | FIFO word shown on port A when mailbox select is low |
| a_dat_o | output | 36 | Port A read data |
| a_oe_o | output | 1 | Port A output enable |
| a_mb1_full_no | output | 1 | Mailbox 1 full flag, writer side (clk_a_i), active low |
| a_mb2_full_no | output | 1 | Mailbox 2 full flag, reader side (clk_a_i), active low |
| b_cs_ni | input | 1 | Port B chip select, active low |
| b_rd_i | input | 1 | Port B direction: 1 = drive outputs, 0 = write into block |
| b_en_i | input | 1 | Port B access enable |
| b_mb_i | input | 1 | Port B mailbox select |
| b_dat_i | input | 36 | Port B write data |
| b_fifo_i | input | 36 | FIFO word shown on port B when mailbox select is low |
| b_dat_o | output | 36 | Port B read data |
| b_oe_o | output | 1 | Port B output enable |
| b_mb1_full_no | output | 1 | Mailbox 1 full flag, reader side (clk_b_i), active low |
| b_mb2_full_no | output | 1 | Mailbox 2 full flag, writer side (clk_b_i), active low |

## Verification
The flag properties assume that no access is attempted in the first few clocks after reset is released, while each domain's synchronized reset is still low. They also assume that each port's controls are steady around its own rising edge. The stimulus meets both conditions: it waits several cycles in each domain after release, and it changes port A inputs only on falling clk_a_i and port B inputs only on falling clk_b_i. The two clocks have unrelated periods, so edges in the two domains never coincide, and the crossing windows in R5 and R6 are checked as a lower bound plus a short polling window rather than a single edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_W = 36;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic oe;
    logic mb_wr;
    logic mb_rd;
  } port_ctl_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter bit WR_WHEN_HIGH = 1'b1
) (
  input  logic      cs_ni,
  input  logic      dir_i,
  input  logic      en_i,
  input  logic      sel_i,
  output port_ctl_t ctl_o
);
  logic wr_dir;

  generate
    if (WR_WHEN_HIGH) begin : g_wr_high
      assign wr_dir = dir_i;
    end else begin : g_wr_low
      assign wr_dir = ~dir_i;
    end
  endgenerate

  always_comb begin
    ctl_o.oe    = ~cs_ni & ~wr_dir;
    ctl_o.mb_wr = ~cs_ni &  wr_dir & en_i & sel_i;
    ctl_o.mb_rd = ~cs_ni & ~wr_dir & en_i & sel_i;
  end
endmodule

// File: rtl/mbox_tgl_sync.sv
module mbox_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
  parameter int W    = 36,
  parameter int SYNC = 2
) (
  input  logic         wclk_i,
  input  logic         wrst_ni,
  input  logic         wreq_i,
  input  logic [W-1:0] wdat_i,
  output logic         wfull_no,
  input  logic         rclk_i,
  input  logic         rrst_ni,
  input  logic         rreq_i,
  output logic [W-1:0] rdat_o,
  output logic         rfull_no
);
  logic [W-1:0] msg_q;
  logic         wtgl_q, rtgl_q;
  logic         wfull_nq, rfull_nq;
  logic         ack_p, new_p;

  // writer domain: word held stable until the reader acknowledges
  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      msg_q    <= '0;
      wtgl_q   <= 1'b0;
      wfull_nq <= 1'b1;
    end else if (wreq_i && wfull_nq) begin
      msg_q    <= wdat_i;
      wtgl_q   <= ~wtgl_q;
      wfull_nq <= 1'b0;
    end else if (ack_p) begin
      wfull_nq <= 1'b1;
    end
  end

  mbox_tgl_sync #(.STAGES(SYNC)) u_to_rd (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .tgl_i  (wtgl_q),
    .pulse_o(new_p)
  );

  // reader domain
  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rtgl_q   <= 1'b0;
      rfull_nq <= 1'b1;
    end else if (new_p) begin
      rfull_nq <= 1'b0;
    end else if (rreq_i && !rfull_nq) begin
      rfull_nq <= 1'b1;
      rtgl_q   <= ~rtgl_q;
    end
  end

  mbox_tgl_sync #(.STAGES(SYNC)) u_to_wr (
    .clk_i  (wclk_i),
    .rst_ni (wrst_ni),
    .tgl_i  (rtgl_q),
    .pulse_o(ack_p)
  );

  assign rdat_o   = msg_q;
  assign wfull_no = wfull_nq;
  assign rfull_no = rfull_nq;
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int W    = MB_W,
  parameter int SYNC = SYNC_STAGES
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         a_cs_ni,
  input  logic         a_wr_i,
  input  logic         a_en_i,
  input  logic         a_mb_i,
  input  logic [W-1:0] a_dat_i,
  input  logic [W-1:0] a_fifo_i,
  output logic [W-1:0] a_dat_o,
  output logic         a_oe_o,
  output logic         a_mb1_full_no,
  output logic         a_mb2_full_no,
  input  logic         b_cs_ni,
  input  logic         b_rd_i,
  input  logic         b_en_i,
  input  logic         b_mb_i,
  input  logic [W-1:0] b_dat_i,
  input  logic [W-1:0] b_fifo_i,
  output logic [W-1:0] b_dat_o,
  output logic         b_oe_o,
  output logic         b_mb1_full_no,
  output logic         b_mb2_full_no
);
  localparam int NCH = 2;

  logic      rst_a_n, rst_b_n;
  port_ctl_t ctl_a, ctl_b;

  logic [NCH-1:0] wclk, rclk, wrst_n, rrst_n, wreq, rreq, wfull_n, rfull_n;
  logic [W-1:0]   wdat [NCH];
  logic [W-1:0]   rdat [NCH];
  logic [W-1:0]   mb1_q, mb2_q;

  mbox_rst_sync #(.STAGES(SYNC)) u_rst_a (.clk_i(clk_a_i), .rst_ni(rst_ni), .rst_no(rst_a_n));
  mbox_rst_sync #(.STAGES(SYNC)) u_rst_b (.clk_i(clk_b_i), .rst_ni(rst_ni), .rst_no(rst_b_n));

  mbox_port_dec #(.WR_WHEN_HIGH(1'b1)) u_dec_a (
    .cs_ni(a_cs_ni), .dir_i(a_wr_i), .en_i(a_en_i), .sel_i(a_mb_i), .ctl_o(ctl_a)
  );
  mbox_port_dec #(.WR_WHEN_HIGH(1'b0)) u_dec_b (
    .cs_ni(b_cs_ni), .dir_i(b_rd_i), .en_i(b_en_i), .sel_i(b_mb_i), .ctl_o(ctl_b)
  );

  // channel 0 = mailbox 1 (A -> B), channel 1 = mailbox 2 (B -> A)
  assign wclk   = {clk_b_i, clk_a_i};
  assign rclk   = {clk_a_i, clk_b_i};
  assign wrst_n = {rst_b_n, rst_a_n};
  assign rrst_n = {rst_a_n, rst_b_n};
  assign wreq   = {ctl_b.mb_wr, ctl_a.mb_wr};
  assign rreq   = {ctl_a.mb_rd, ctl_b.mb_rd};
  assign wdat[0] = a_dat_i;
  assign wdat[1] = b_dat_i;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      mbox_chan #(.W(W), .SYNC(SYNC)) u_ch (
        .wclk_i  (wclk[c]),
        .wrst_ni (wrst_n[c]),
        .wreq_i  (wreq[c]),
        .wdat_i  (wdat[c]),
        .wfull_no(wfull_n[c]),
        .rclk_i  (rclk[c]),
        .rrst_ni (rrst_n[c]),
        .rreq_i  (rreq[c]),
        .rdat_o  (rdat[c]),
        .rfull_no(rfull_n[c])
      );
    end
  endgenerate

  assign mb1_q = rdat[0];
  assign mb2_q = rdat[1];

  assign a_oe_o  = ctl_a.oe;
  assign b_oe_o  = ctl_b.oe;
  assign a_dat_o = !ctl_a.oe ? '0 : (a_mb_i ? mb2_q : a_fifo_i);
  assign b_dat_o = !ctl_b.oe ? '0 : (b_mb_i ? mb1_q : b_fifo_i);

  assign a_mb1_full_no = wfull_n[0];
  assign b_mb1_full_no = rfull_n[0];
  assign b_mb2_full_no = wfull_n[1];
  assign a_mb2_full_no = rfull_n[1];
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int W = 36
) (
  input logic         clk_a_i,
  input logic         clk_b_i,
  input logic         rst_ni,
  input logic         a_cs_ni,
  input logic         a_wr_i,
  input logic         a_en_i,
  input logic         a_mb_i,
  input logic         a_oe_o,
  input logic [W-1:0] a_dat_o,
  input logic         a_mb1_full_no,
  input logic         a_mb2_full_no,
  input logic         b_cs_ni,
  input logic         b_rd_i,
  input logic         b_en_i,
  input logic         b_mb_i,
  input logic         b_oe_o,
  input logic [W-1:0] b_dat_o,
  input logic         b_mb1_full_no,
  input logic         b_mb2_full_no,
  input logic [W-1:0] mb1_q,
  input logic [W-1:0] mb2_q
);
  always @(negedge clk_a_i) begin
    if (!rst_ni) begin
      p_rst_flags_r1: assert (a_mb1_full_no && a_mb2_full_no && b_mb1_full_no && b_mb2_full_no);
    end
  end

  p_mb1_wr_r2: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_cs_ni && a_wr_i && a_en_i && a_mb_i && a_mb1_full_no) |=> !a_mb1_full_no);

  p_mb2_wr_r3: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_cs_ni && !b_rd_i && b_en_i && b_mb_i && b_mb2_full_no) |=> !b_mb2_full_no);

  p_mb1_keep_r4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_mb1_full_no |=> $stable(mb1_q));

  p_mb2_keep_r4: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !b_mb2_full_no |=> $stable(mb2_q));

  p_mb1_rd_after_wr_r5: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $fell(b_mb1_full_no) |-> !a_mb1_full_no);

  p_mb1_rd_r6: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_cs_ni && b_rd_i && b_en_i && b_mb_i && !b_mb1_full_no) |=> b_mb1_full_no);

  p_mb2_rd_r6: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_cs_ni && !a_wr_i && a_en_i && a_mb_i && !a_mb2_full_no) |=> a_mb2_full_no);

  p_mux_b_r7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_oe_o && b_mb_i) |-> (b_dat_o == mb1_q));

  p_mux_a_r7: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_oe_o && a_mb_i) |-> (a_dat_o == mb2_q));
endmodule

bind mbox_pair mbox_pair_chk #(.W(W)) u_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .a_cs_ni(a_cs_ni), .a_wr_i(a_wr_i), .a_en_i(a_en_i), .a_mb_i(a_mb_i),
  .a_oe_o(a_oe_o), .a_dat_o(a_dat_o),
  .a_mb1_full_no(a_mb1_full_no), .a_mb2_full_no(a_mb2_full_no),
  .b_cs_ni(b_cs_ni), .b_rd_i(b_rd_i), .b_en_i(b_en_i), .b_mb_i(b_mb_i),
  .b_oe_o(b_oe_o), .b_dat_o(b_dat_o),
  .b_mb1_full_no(b_mb1_full_no), .b_mb2_full_no(b_mb2_full_no),
  .mb1_q(mb1_q), .mb2_q(mb2_q)
);

// File: tb/sim_mbox_pair.sv
`timescale 1ns/1ps
module sim_mbox_pair;
  localparam int W = 36;

  logic clk_a_i = 1'b0, clk_b_i = 1'b0, rst_ni = 1'b0;
  logic a_cs_ni = 1'b1, a_wr_i = 1'b0, a_en_i = 1'b0, a_mb_i = 1'b0;
  logic b_cs_ni = 1'b1, b_rd_i = 1'b0, b_en_i = 1'b0, b_mb_i = 1'b0;
  logic [W-1:0] a_dat_i = '0, a_fifo_i = '0, b_dat_i = '0, b_fifo_i = '0;
  logic [W-1:0] a_dat_o, b_dat_o;
  logic a_oe_o, b_oe_o, a_mb1_full_no, a_mb2_full_no, b_mb1_full_no, b_mb2_full_no;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5   clk_a_i = ~clk_a_i;
  always #7.3 clk_b_i = ~clk_b_i;

  mbox_pair u0 (.*);

  // bits: a_cs_n, a_wr, b_cs_n, b_rd, exp a_oe, exp b_oe
  localparam logic [5:0] VEC [6] = '{
    6'b000111, 6'b010000, 6'b101100, 6'b110101, 6'b001010, 6'b010101
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic write_a(input logic [W-1:0] v);
    @(negedge clk_a_i);
    a_cs_ni = 0; a_wr_i = 1; a_en_i = 1; a_mb_i = 1; a_dat_i = v;
    @(posedge clk_a_i); #1;
    a_en_i = 0; a_cs_ni = 1;
  endtask

  task automatic write_b(input logic [W-1:0] v);
    @(negedge clk_b_i);
    b_cs_ni = 0; b_rd_i = 0; b_en_i = 1; b_mb_i = 1; b_dat_i = v;
    @(posedge clk_b_i); #1;
    b_en_i = 0; b_cs_ni = 1;
  endtask

  task automatic edges_a(input int n);
    repeat (n) @(posedge clk_a_i);
    #1;
  endtask

  task automatic edges_b(input int n);
    repeat (n) @(posedge clk_b_i);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_a_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
    end
  end

  localparam logic [W-1:0] V1 = 36'h9_ABCD_1234;
  localparam logic [W-1:0] V2 = 36'h1_5566_7788;
  localparam logic [W-1:0] V3 = 36'hC_0FFE_E001;
  localparam logic [W-1:0] FB = 36'h3_3333_0000;
  localparam logic [W-1:0] FA = 36'h4_4444_1111;

  initial begin
    // R1 reset state
    #30;
    b_cs_ni = 0; b_rd_i = 1; b_mb_i = 1;
    a_cs_ni = 0; a_wr_i = 0; a_mb_i = 1;
    #1;
    chk({a_mb1_full_no, a_mb2_full_no, b_mb1_full_no, b_mb2_full_no} == 4'hF, "R1 flags", {a_mb1_full_no, a_mb2_full_no, b_mb1_full_no, b_mb2_full_no}, 4'hF);
    chk(b_dat_o == '0, "R1 mb1 word", b_dat_o, 0);
    chk(a_dat_o == '0, "R1 mb2 word", a_dat_o, 0);
    a_cs_ni = 1; b_cs_ni = 1;
    @(negedge clk_a_i); rst_ni = 1;
    edges_a(5); edges_b(5);

    // R8 output enable decode, enables held low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a_i);
      {a_cs_ni, a_wr_i, b_cs_ni, b_rd_i} = VEC[i][5:2];
      #1;
      chk(a_oe_o == VEC[i][1], "R8 a_oe", a_oe_o, VEC[i][1]);
      chk(b_oe_o == VEC[i][0], "R8 b_oe", b_oe_o, VEC[i][0]);
    end
    a_cs_ni = 1; b_cs_ni = 1; a_wr_i = 0; b_rd_i = 0;

    // mailbox 1: write on A
    write_a(V1);
    chk(!a_mb1_full_no, "R2 writer flag low", a_mb1_full_no, 0);
    edges_b(2);
    chk(b_mb1_full_no, "R5 reader flag still high", b_mb1_full_no, 1);
    for (int i = 0; i < 2; i++) if (b_mb1_full_no) edges_b(1);
    chk(!b_mb1_full_no, "R5 reader flag low", b_mb1_full_no, 0);

    // R4 overwrite blocked
    write_a(V2);
    chk(!a_mb1_full_no, "R4 writer flag stays low", a_mb1_full_no, 0);
    @(negedge clk_b_i);
    b_cs_ni = 0; b_rd_i = 1; b_mb_i = 1; b_en_i = 0; b_fifo_i = FB;
    #1;
    chk(b_dat_o == V1, "R4 word kept", b_dat_o, V1);
    chk(b_dat_o == V1, "R7 mailbox shown", b_dat_o, V1);
    b_mb_i = 0; #1;
    chk(b_dat_o == FB, "R7 fifo shown", b_dat_o, FB);
    b_cs_ni = 1; #1;
    chk(b_dat_o == '0, "R7 disabled zero", b_dat_o, 0);

    // R9 ignored reads
    @(negedge clk_b_i); b_cs_ni = 0; b_mb_i = 1; b_en_i = 0;
    edges_b(1);
    chk(!b_mb1_full_no, "R9 en low read ignored", b_mb1_full_no, 0);
    @(negedge clk_b_i); b_en_i = 1; b_mb_i = 0;
    edges_b(1);
    chk(!b_mb1_full_no, "R9 sel low read ignored", b_mb1_full_no, 0);

    // R6 read mailbox 1 on B
    @(negedge clk_b_i); b_mb_i = 1; b_en_i = 1;
    @(posedge clk_b_i); #1; b_en_i = 0; b_cs_ni = 1;
    chk(b_mb1_full_no, "R6 reader flag high", b_mb1_full_no, 1);
    edges_a(2);
    chk(!a_mb1_full_no, "R6 writer flag still low", a_mb1_full_no, 0);
    for (int i = 0; i < 2; i++) if (!a_mb1_full_no) edges_a(1);
    chk(a_mb1_full_no, "R6 writer flag high", a_mb1_full_no, 1);

    // new write accepted after acknowledge
    write_a(V2);
    chk(!a_mb1_full_no, "R2 second write", a_mb1_full_no, 0);
    edges_b(4);
    b_cs_ni = 0; b_rd_i = 1; b_mb_i = 1; #1;
    chk(b_dat_o == V2, "R2 stored word", b_dat_o, V2);
    b_cs_ni = 1;

    // mailbox 2: write on B, read on A
    write_b(V3);
    chk(!b_mb2_full_no, "R3 writer flag low", b_mb2_full_no, 0);
    edges_a(2);
    chk(a_mb2_full_no, "R5 mb2 reader flag still high", a_mb2_full_no, 1);
    for (int i = 0; i < 2; i++) if (a_mb2_full_no) edges_a(1);
    chk(!a_mb2_full_no, "R5 mb2 reader flag low", a_mb2_full_no, 0);
    write_b(V1);
    @(negedge clk_a_i);
    a_cs_ni = 0; a_wr_i = 0; a_mb_i = 1; a_en_i = 0; a_fifo_i = FA; #1;
    chk(a_dat_o == V3, "R4 mb2 word kept", a_dat_o, V3);
    a_mb_i = 0; #1;
    chk(a_dat_o == FA, "R7 port A fifo shown", a_dat_o, FA);
    @(negedge clk_a_i); a_mb_i = 1; a_en_i = 1;
    @(posedge clk_a_i); #1; a_en_i = 0;
    chk(a_mb2_full_no, "R6 mb2 reader flag high", a_mb2_full_no, 1);
    edges_b(2);
    chk(!b_mb2_full_no, "R6 mb2 writer flag still low", b_mb2_full_no, 0);
    for (int i = 0; i < 2; i++) if (!b_mb2_full_no) edges_b(1);
    chk(b_mb2_full_no, "R6 mb2 writer flag high", b_mb2_full_no, 1);

    // R1 asynchronous reset while mailbox 2 full
    write_b(V2);
    edges_a(5);
    chk(!a_mb2_full_no, "R5 mb2 full before reset", a_mb2_full_no, 0);
    #2.1 rst_ni = 0; #1;
    chk({a_mb1_full_no, a_mb2_full_no, b_mb1_full_no, b_mb2_full_no} == 4'hF, "R1 async flags", {a_mb1_full_no, a_mb2_full_no, b_mb1_full_no, b_mb2_full_no}, 4'hF);
    chk(a_dat_o == '0, "R1 async word cleared", a_dat_o, 0);

    done = 1'b1;
    report();
  end
endmodule